// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to `NUM_SRC` interrupt requests, decides which of them the CPU should service next, and tells the CPU sequencer when to enter a handler and at which vector. Vector index 0 belongs to reset. Source `i` owns vector index `i+1`, and the lower the index, the higher its priority. A global enable bit gates every source, and each source also has its own enable bit.

A source is either sticky or level-sensitive, as the `LEVEL_MASK` parameter chooses. A sticky source latches a pending flag that stays set until the handler is entered or software clears it by writing a one to the flag's bit position. A level source asks for service only while its input is high, and it keeps no record of past requests.

The CPU marks every instruction boundary with `insn_done`. An interrupt can only be taken at such a boundary. The block reports the take one cycle later, together with the vector index and a vector address. `vec_base_sel` moves that address from zero to the boot section base.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Among the eligible sources, the one with the lowest number wins. Source `i` is reported as `irq_index = i+1`, so index 0 is never produced by a take.
- R2: A source is taken only at a cycle with `insn_done` high, and only when its own enable bit and the global enable bit are both 1. Enable bits load from `en_wdata` on `en_wr` and take effect from the next cycle.
- R3: Taking an interrupt clears the global enable. `sei` or `reti` sets it from the next cycle on. `cli` clears it, and `cli` wins over `sei` and `reti` in the same cycle.
- R4: On a sticky source, a high input sets the pending flag even while the source is disabled. The flag stays set until it is cleared. Entering that source's vector clears it. An input that is high in the same cycle sets it again.
- R5: When `clr_wr` is high, every flag whose bit in `clr_wdata` is 1 is cleared. Bits written as 0 leave their flags unchanged.
- R6: A level source has no flag: its `flag_pend` bit is always 0. It requests only in the cycles where its input is high, so a request that is gone before the source is enabled is lost.
- R7: No interrupt is taken in the cycle of `reti`, nor at the first `insn_done` after it. One instruction of the interrupted program therefore completes before the next take.
- R8: No interrupt is taken in a cycle where `cli` is high, even when the global enable is still 1 and a request is eligible in that cycle.
- R9: The vector address is `(vec_base_sel ? BOOT_BASE : 0) + irq_index * VEC_SLOT`, with `vec_base_sel` sampled at the take. `irq_index` and `irq_vaddr` hold their values until the next take.
- R10: `irq_take` is a one-cycle pulse, and two takes are never in consecutive cycles. When several flags are pending, they are serviced one per handler entry, in priority order, each time the global enable is set again.
- R11: After reset, the global enable, all enables, all flags, `irq_take`, `irq_index` and `irq_vaddr` are 0. Reset is asserted asynchronously and released through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Per-source request inputs |
| en_wr | input | 1 | Load per-source enables |
| en_wdata | input | NUM_SRC | New per-source enable values |
| clr_wr | input | 1 | Write-one-to-clear strobe for flags |
| clr_wdata | input | NUM_SRC | Flags to clear |
| cli | input | 1 | Clear global enable |
| sei | input | 1 | Set global enable |
| reti | input | 1 | Return from interrupt |
| insn_done | input | 1 | Instruction boundary strobe |
| vec_base_sel | input | 1 | 1 selects the boot section vector base |
| irq_take | output | 1 | Interrupt taken (one-cycle pulse) |
| irq_index | output | $clog2(NUM_SRC+1) | Vector index of the last take |
| irq_vaddr | output | ADDR_W | Vector address of the last take |
| gie | output | 1 | Global enable state |
| flag_pend | output | NUM_SRC | Pending flags of the sticky sources |

## Verification
The bench builds the block with six sources. Sources 4 and 5 are level-type and sources 0 to 3 are sticky. `VEC_SLOT` is 4 and `BOOT_BASE` is 0x1E00. With these values, sticky and level behaviour can both be observed in one run, and both vector bases produce distinct, non-trivial addresses. Directed sequences cover the priority order after a masked period, the post-return guard, a `cli` that arrives together with a boundary, and a level request that is lost. A long random phase then crosses clears, enable writes and strobes against every state.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  // Returns the lowest set bit position of a request vector (0 if none).
  function automatic int unsigned lowest_set(input logic [63:0] vec, input int unsigned width);
    int unsigned pos;
    pos = 0;
    for (int i = int'(width) - 1; i >= 0; i--) begin
      if (vec[i]) pos = i;
    end
    return pos;
  endfunction

endpackage

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
  parameter int unsigned           NUM_SRC    = 8,
  parameter logic [NUM_SRC-1:0]    LEVEL_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_wdata,
  input  logic [NUM_SRC-1:0] ack_vec,
  output logic [NUM_SRC-1:0] req_vec,
  output logic [NUM_SRC-1:0] flag_q
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign req_vec[i] = src_in[i];
      assign flag_q[i]  = 1'b0;
    end else begin : g_sticky
      logic flag_r;
      logic flag_nxt;
      logic flag_ce;

      always_comb begin
        flag_nxt = flag_r;
        if ((clr_wr && clr_wdata[i]) || ack_vec[i]) flag_nxt = 1'b0;
        if (src_in[i]) flag_nxt = 1'b1;
        flag_ce = (flag_nxt != flag_r);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_r <= 1'b0;
        else if (flag_ce) flag_r <= flag_nxt;
      end

      assign req_vec[i] = flag_r;
      assign flag_q[i]  = flag_r;
    end
  end

endmodule

// File: rtl/ivc_prio_arb.sv
module ivc_prio_arb #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IW     = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] elig_vec,
  output logic               any_elig,
  output logic [IW-1:0]      win_index,
  output logic [NUM_SRC-1:0] win_onehot
);
  import ivc_pkg::*;

  logic [63:0] padded;
  int unsigned pos;

  always_comb begin
    padded     = '0;
    padded[NUM_SRC-1:0] = elig_vec;
    pos        = lowest_set(padded, NUM_SRC);
    any_elig   = |elig_vec;
    win_index  = any_elig ? IW'(pos + 1) : '0;
    win_onehot = '0;
    if (any_elig) win_onehot[pos] = 1'b1;
  end

endmodule

// File: rtl/ivc_gate.sv
module ivc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cli,
  input  logic sei,
  input  logic reti,
  input  logic insn_done,
  input  logic any_elig,
  output logic take_now,
  output logic gie_q
);

  logic hold_q;
  logic gie_nxt, hold_nxt;

  always_comb begin
    take_now = insn_done && gie_q && !cli && !reti && !hold_q && any_elig;

    gie_nxt = gie_q;
    if (take_now)         gie_nxt = 1'b0;
    else if (cli)         gie_nxt = 1'b0;
    else if (sei || reti) gie_nxt = 1'b1;

    hold_nxt = hold_q;
    if (reti)           hold_nxt = 1'b1;
    else if (insn_done) hold_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      gie_q  <= gie_nxt;
      hold_q <= hold_nxt;
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned        NUM_SRC    = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  parameter int unsigned        ADDR_W     = 16,
  parameter int unsigned        VEC_SLOT   = 2,
  parameter logic [ADDR_W-1:0]  BOOT_BASE  = 16'hF000,
  localparam int unsigned       IW         = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_wdata,
  input  logic               cli,
  input  logic               sei,
  input  logic               reti,
  input  logic               insn_done,
  input  logic               vec_base_sel,
  output logic               irq_take,
  output logic [IW-1:0]      irq_index,
  output logic [ADDR_W-1:0]  irq_vaddr,
  output logic               gie,
  output logic [NUM_SRC-1:0] flag_pend
);

  // Reset synchronizer: asynchronous assert, synchronous release.
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] req_vec, elig_vec, win_onehot, ack_vec;
  logic               any_elig, take_now;
  logic [IW-1:0]      win_index;
  logic [ADDR_W-1:0]  base_addr, vaddr_nxt;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  en_q <= '0;
    else if (en_wr)  en_q <= en_wdata;
  end

  ivc_flag_bank #(
    .NUM_SRC    (NUM_SRC),
    .LEVEL_MASK (LEVEL_MASK)
  ) u_flags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .src_in    (src_in),
    .clr_wr    (clr_wr),
    .clr_wdata (clr_wdata),
    .ack_vec   (ack_vec),
    .req_vec   (req_vec),
    .flag_q    (flag_pend)
  );

  assign elig_vec = req_vec & en_q;

  ivc_prio_arb #(
    .NUM_SRC (NUM_SRC)
  ) u_arb (
    .elig_vec   (elig_vec),
    .any_elig   (any_elig),
    .win_index  (win_index),
    .win_onehot (win_onehot)
  );

  ivc_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cli       (cli),
    .sei       (sei),
    .reti      (reti),
    .insn_done (insn_done),
    .any_elig  (any_elig),
    .take_now  (take_now),
    .gie_q     (gie)
  );

  assign ack_vec = take_now ? win_onehot : '0;

  always_comb begin
    base_addr = vec_base_sel ? BOOT_BASE : '0;
    vaddr_nxt = base_addr + ADDR_W'(win_index) * ADDR_W'(VEC_SLOT);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_take <= 1'b0;
    else            irq_take <= take_now;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_index <= '0;
      irq_vaddr <= '0;
    end else if (take_now) begin
      irq_index <= win_index;
      irq_vaddr <= vaddr_nxt;
    end
  end

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int unsigned  NUM_SRC = 8,
  localparam int unsigned IW      = $clog2(NUM_SRC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cli,
  input logic          sei,
  input logic          reti,
  input logic          irq_take,
  input logic [IW-1:0] irq_index,
  input logic          gie
);

  p_take_clears_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !gie);

  p_sei_sets_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sei && !cli) |-> (gie || irq_take));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);

  p_cli_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cli) |-> !irq_take);

  p_reti_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reti) |-> !irq_take);

  p_index_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_index != '0) && (int'(irq_index) <= int'(NUM_SRC)));

endmodule

bind irq_vector_ctrl ivc_checker #(.NUM_SRC(NUM_SRC)) u_ivc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cli       (cli),
  .sei       (sei),
  .reti      (reti),
  .irq_take  (irq_take),
  .irq_index (irq_index),
  .gie       (gie)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;

  localparam int unsigned N     = 6;
  localparam logic [N-1:0] LVL  = 6'b110000;
  localparam int unsigned AW    = 16;
  localparam int unsigned SLOT  = 4;
  localparam logic [AW-1:0] BOOT = 16'h1E00;
  localparam int unsigned IW    = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_in = '0, en_wdata = '0, clr_wdata = '0;
  logic en_wr = 0, clr_wr = 0, cli = 0, sei = 0, reti = 0, insn_done = 0, vec_base_sel = 0;
  logic irq_take, gie;
  logic [IW-1:0] irq_index;
  logic [AW-1:0] irq_vaddr;
  logic [N-1:0] flag_pend;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(
    .NUM_SRC(N), .LEVEL_MASK(LVL), .ADDR_W(AW), .VEC_SLOT(SLOT), .BOOT_BASE(BOOT)
  ) i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .en_wr(en_wr), .en_wdata(en_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .cli(cli), .sei(sei), .reti(reti),
    .insn_done(insn_done), .vec_base_sel(vec_base_sel), .irq_take(irq_take),
    .irq_index(irq_index), .irq_vaddr(irq_vaddr), .gie(gie), .flag_pend(flag_pend)
  );

  int n_run = 0;
  int n_fail = 0;

  // Reference state, built from the requirements.
  logic          m_gie = 0, m_hold = 0, m_take = 0;
  logic [N-1:0]  m_flag = '0, m_en = '0;
  logic [IW-1:0] m_idx = '0;
  logic [AW-1:0] m_addr = '0;

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < int'(N); i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic bsel, input logic [IW-1:0] idx);
    return (bsel ? BOOT : 16'h0) + AW'(idx) * AW'(SLOT);
  endfunction

  task automatic model_step();
    logic [N-1:0] req, elig, ack;
    int w;
    logic want;
    req  = (m_flag & ~LVL) | (src_in & LVL);     // R4 / R6
    elig = req & m_en;                           // R2
    w    = lowest(elig);                         // R1
    want = insn_done && m_gie && !cli && !reti && !m_hold && (w >= 0); // R7 R8
    ack  = '0;
    if (want) ack[w] = 1'b1;
    m_flag = ((m_flag & ~(clr_wr ? clr_wdata : '0) & ~ack) | src_in) & ~LVL; // R4 R5
    if (en_wr) m_en = en_wdata;
    if (want) m_gie = 0; else if (cli) m_gie = 0; else if (sei || reti) m_gie = 1; // R3
    if (reti) m_hold = 1; else if (insn_done) m_hold = 0;
    m_take = want;
    if (want) begin
      m_idx  = IW'(w + 1);
      m_addr = exp_addr(vec_base_sel, IW'(w + 1)); // R9
    end
  endtask

  task automatic compare(input string tag);
    n_run++;
    if (irq_take !== m_take || irq_index !== m_idx || irq_vaddr !== m_addr ||
        gie !== m_gie || flag_pend !== m_flag) begin
      n_fail++;
      $display("FAIL %s: actual take=%0b idx=%0d addr=%h gie=%0b flags=%b expected take=%0b idx=%0d addr=%h gie=%0b flags=%b",
               tag, irq_take, irq_index, irq_vaddr, gie, flag_pend,
               m_take, m_idx, m_addr, m_gie, m_flag);
    end
  endtask

  task automatic step(input string tag);
    model_step();
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
    src_in = '0; en_wr = 0; clr_wr = 0; cli = 0; sei = 0; reti = 0; insn_done = 0;
    en_wdata = '0; clr_wdata = '0;
  endtask

  task automatic expect_take(input string tag, input logic [IW-1:0] idx);
    n_run++;
    if (!(irq_take === 1'b1 && irq_index === idx)) begin
      n_fail++;
      $display("FAIL %s: actual take=%0b idx=%0d expected take=1 idx=%0d", tag, irq_take, irq_index, idx);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    n_run++;
    if (irq_take !== 0 || irq_index !== '0 || irq_vaddr !== '0 || gie !== 0 || flag_pend !== '0) begin
      n_fail++;
      $display("FAIL R11: actual take=%0b idx=%0d addr=%h gie=%0b flags=%b expected all zero",
               irq_take, irq_index, irq_vaddr, gie, flag_pend);
    end

    // R4: event on disabled sticky source latches and holds
    src_in = 6'b000100; step("R4 set while disabled");
    step("R4 held");
    // R2: global on, source disabled -> no take
    sei = 1; step("R3 sei");
    insn_done = 1; step("R2 disabled source");
    en_wr = 1; en_wdata = 6'b111111; step("R2 enable");
    insn_done = 1; step("R2 take");
    expect_take("R4 take clears flag", 3);
    // R5: write-one-to-clear
    src_in = 6'b000011; step("R5 set two");
    clr_wr = 1; clr_wdata = 6'b000010; step("R5 clear one");
    clr_wr = 1; clr_wdata = 6'b000001; step("R5 clear other");
    // R10 / R1: several pending while masked
    src_in = 6'b001001; step("R10 set pending");
    sei = 1; step("R10 sei");
    insn_done = 1; step("R1 lowest wins");
    expect_take("R1 index", 1);
    reti = 1; step("R7 reti");
    insn_done = 1; step("R7 guarded boundary");
    vec_base_sel = 1;
    insn_done = 1; step("R10 second take");
    expect_take("R10 index", 4);
    n_run++;
    if (irq_vaddr !== BOOT + 16'd16) begin
      n_fail++; $display("FAIL R9: actual %h expected %h", irq_vaddr, BOOT + 16'd16);
    end
    vec_base_sel = 0;
    // R6: level request lost before enable
    en_wr = 1; en_wdata = 6'b000000; step("R6 disable");
    src_in = 6'b010000; step("R6 level high");
    src_in = 6'b010000; step("R6 level high");
    en_wr = 1; en_wdata = 6'b111111; sei = 1; step("R6 enable after drop");
    insn_done = 1; step("R6 lost request");
    // R8: cli same cycle as boundary
    src_in = 6'b000010; step("R8 pend");
    cli = 1; insn_done = 1; step("R8 cli blocks");
    sei = 1; step("R8 sei");
    insn_done = 1; step("R8 later take");
    expect_take("R9 base zero index", 2);
    n_run++;
    if (irq_vaddr !== 16'd8) begin
      n_fail++; $display("FAIL R9: actual %h expected %h", irq_vaddr, 16'd8);
    end

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      src_in       = N'($urandom) & N'($urandom) & N'($urandom);
      en_wr        = ($urandom % 20) == 0;
      en_wdata     = N'($urandom);
      clr_wr       = ($urandom % 10) == 0;
      clr_wdata    = N'($urandom);
      cli          = ($urandom % 16) == 0;
      sei          = ($urandom % 6) == 0;
      reti         = ($urandom % 12) == 0;
      insn_done    = ($urandom % 2) == 0;
      if (($urandom % 50) == 0) vec_base_sel = ~vec_base_sel;
      step("RND R1 R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule